// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for a paged memory system with 4 KB pages. A caller presents the linear address together with the current directory base value. The walker then fetches one directory entry and one page table entry from memory, one after the other, and returns the physical address. If either entry is marked not present, it reports a page fault instead.

The linear address is cut into three fields. Bits 31:22 index the page directory. Bits 21:12 index the page table. Bits 11:0 are the byte offset inside the page. Each entry is 32 bits wide. Bits 31:12 of an entry hold the base of the next level: the page table for a directory entry, or the page frame for a table entry. Bit 0 of an entry is the present flag.

Memory reads use a one-cycle request pulse and a later valid strobe that carries the data. Any number of cycles may pass between the two, so the walker fits behind a cache or an arbitrated memory port.

Top module: `ptw_top`

## Requirements
- R1: After the asynchronous reset is released, `req_ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: A request is taken only when `req_valid_i` and `req_ready_o` are both 1. A request made while a walk is in progress is ignored: it changes neither the current result nor starts a further walk.
- R3: The first read goes to the directory base with bits 11:0 cleared, plus 4 times linear address bits 31:22.
- R4: If the directory entry has bit 0 set, the second read goes to directory entry bits 31:12 with bits 11:0 zero, plus 4 times linear address bits 21:12.
- R5: If the table entry has bit 0 set, `done_o` is 1 for one cycle. During that cycle `paddr_o` equals table entry bits 31:12 joined with linear address bits 11:0.
- R6: A directory entry with bit 0 clear ends the walk. The second read is not issued, `fault_o` is 1 for one cycle, and `fault_laddr_o` carries the linear address.
- R7: A table entry with bit 0 clear sets `fault_o` for one cycle with the faulting linear address, and `done_o` stays 0.
- R8: Each read is a single-cycle `mem_req_o` pulse. Any response latency of one cycle or more is accepted. Only one read is outstanding at any time.
- R9: A `mem_rvalid_i` strobe that arrives while no read is outstanding has no effect.
- R10: `done_o` and `fault_o` are never both 1. In the cycle after either one, `req_ready_o` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_laddr_i | input | 32 | Linear address to translate |
| req_root_i | input | 32 | Page directory base value |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 32 | Read address, held while the read is outstanding |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Translation finished (one cycle) |
| paddr_o | output | 32 | Physical address, valid with done_o |
| fault_o | output | 1 | Page fault (one cycle) |
| fault_laddr_o | output | 32 | Faulting linear address, valid with fault_o |

## Verification
The assertions assume that memory returns exactly one `mem_rvalid_i` strobe for each `mem_req_o` pulse, at least one cycle later, and that `mem_rdata_i` matters only while that strobe is high. The walker samples the request fields only at acceptance, so the assertions place no limit on how those fields change at other times. The bench acts as the memory. It answers each request pulse once, after a fixed delay of one cycle or more. It drives spurious strobes only while the walker is idle, which is the case R9 covers.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned ENT_LG  = 2;   // log2 of entry size in bytes
  localparam int unsigned LEVELS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_LG = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BASE_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] idx_off;

  always_comb begin
    base_al = {base_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    idx_off = ADDR_W'(idx_i) << ENT_LG;
    addr_o  = base_al + idx_off;
  end

  logic unused_low;
  assign unused_low = ^base_i[OFF_W-1:0] & (BASE_W > 0);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     rvalid_i,
  input  logic     present_i,
  output walk_st_e st_o,
  output logic     issue_o,
  output logic     take_o,
  output logic     ready_o
);
  walk_st_e st_q, st_d;
  logic     pend_q;
  logic     reading;

  assign reading = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL);
  assign issue_o = reading && !pend_q;
  assign take_o  = reading && pend_q && rvalid_i;
  assign ready_o = (st_q == ST_IDLE);
  assign st_o    = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_RD_DIR;
      ST_RD_DIR: if (take_o)  st_d = present_i ? ST_RD_TBL : ST_FAULT;
      ST_RD_TBL: if (take_o)  st_d = present_i ? ST_DONE   : ST_FAULT;
      ST_DONE:   st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (issue_o)     pend_q <= 1'b1;
      else if (take_o) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned AW      = ptw_pkg::ADDR_W,
  parameter int unsigned IW      = ptw_pkg::IDX_W,
  parameter int unsigned OW      = ptw_pkg::OFF_W,
  parameter int unsigned EL      = ptw_pkg::ENT_LG,
  parameter int unsigned PRES_B  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_laddr_i,
  input  logic [AW-1:0] req_root_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] paddr_o,
  output logic          fault_o,
  output logic [AW-1:0] fault_laddr_o
);
  localparam int unsigned NLVL = ptw_pkg::LEVELS;

  walk_st_e st;
  logic     issue, take, accept;
  logic [AW-1:0] laddr_q, root_q, tbl_q, frame_q;
  logic [AW-1:0] lvl_base [NLVL];
  logic [IW-1:0] lvl_idx  [NLVL];
  logic [AW-1:0] lvl_addr [NLVL];

  assign accept = req_valid_i && req_ready_o;

  ptw_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (req_valid_i),
    .rvalid_i  (mem_rvalid_i),
    .present_i (mem_rdata_i[PRES_B]),
    .st_o      (st),
    .issue_o   (issue),
    .take_o    (take),
    .ready_o   (req_ready_o)
  );

  // level 0 indexes with the top field, level 1 with the next one down
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_base[g] = (g == 0) ? root_q : tbl_q;
    assign lvl_idx[g]  = laddr_q[AW-1-g*IW -: IW];
    ptw_addr_gen #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW), .ENT_LG(EL)) u_ag (
      .base_i (lvl_base[g]),
      .idx_i  (lvl_idx[g]),
      .addr_o (lvl_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      frame_q <= '0;
    end else begin
      if (accept) begin
        laddr_q <= req_laddr_i;
        root_q  <= req_root_i;
      end
      if (take && st == ST_RD_DIR) tbl_q   <= mem_rdata_i;
      if (take && st == ST_RD_TBL) frame_q <= mem_rdata_i;
    end
  end

  assign mem_req_o     = issue;
  assign mem_addr_o    = (st == ST_RD_TBL) ? lvl_addr[1] : lvl_addr[0];
  assign done_o        = (st == ST_DONE);
  assign fault_o       = (st == ST_FAULT);
  assign paddr_o       = {frame_q[AW-1:OW], laddr_q[OW-1:0]};
  assign fault_laddr_o = laddr_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_laddr_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          done_o,
  input logic [AW-1:0] paddr_o,
  input logic          fault_o,
  input logic [AW-1:0] fault_laddr_o
);
  logic [AW-1:0] cap_q;
  logic          outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      outst_q <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) cap_q <= req_laddr_i;
      if (mem_req_o)         outst_q <= 1'b1;
      else if (mem_rvalid_i) outst_q <= 1'b0;
    end
  end

  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);
  a_r8_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst_q && !mem_rvalid_i) |=> $stable(mem_addr_o));
  a_r3_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (paddr_o[OW-1:0] == cap_q[OW-1:0]));
  a_r6_fault_laddr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_laddr_o == cap_q));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  a_r10_back_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> (req_ready_o && !done_o && !fault_o));
endmodule

bind ptw_top ptw_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_laddr_i   (req_laddr_i),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .done_o        (done_o),
  .paddr_o       (paddr_o),
  .fault_o       (fault_o),
  .fault_laddr_o (fault_laddr_o)
);

// File: tb/sim_ptw_top.sv
`timescale 1ns/1ps
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic [31:0] req_root = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] paddr;
  logic        fault;
  logic [31:0] fault_laddr;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ptw_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_laddr_i(req_laddr), .req_root_i(req_root),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .paddr_o(paddr),
    .fault_o(fault), .fault_laddr_o(fault_laddr)
  );

  typedef struct packed {
    logic [31:0] laddr;
    logic [31:0] root;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_3123, 32'h0010_0000, 32'h0020_0001, 32'h0ABC_D007, 4'd0},
    '{32'hFFFF_FFFF, 32'h1234_5FFF, 32'h8765_4ABF, 32'hFFFF_F001, 4'd3},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 4'd1},
    '{32'h1234_5678, 32'h0008_0000, 32'h0000_0FFE, 32'h0000_0001, 4'd2},
    '{32'h8000_1ABC, 32'h0000_3000, 32'h0005_0003, 32'hFFFF_F000, 4'd5},
    '{32'h0C03_F800, 32'h0000_7000, 32'h1000_0001, 32'h4000_0001, 4'd15}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  // memory side: wait one cycle plus latency after a request, then respond
  task automatic respond(input logic [31:0] data, input logic [3:0] lat);
    @(negedge clk);
    for (int k = 0; k < lat; k++) begin
      chk(mem_req == 1'b0, "R8 no repeat request", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
    end
    mem_rvalid = 1'b1;
    mem_rdata  = data;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  endtask

  task automatic start_req(input logic [31:0] la, input logic [31:0] rt);
    req_valid = 1'b1;
    req_laddr = la;
    req_root  = rt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] e_dir, e_tbl, e_pa;
    e_dir = {v.root[31:12], 12'h000} + {20'h0, v.laddr[31:22], 2'b00};
    e_tbl = {v.pde[31:12], 12'h000} + {20'h0, v.laddr[21:12], 2'b00};
    e_pa  = {v.pte[31:12], v.laddr[11:0]};
    chk(req_ready == 1'b1, "R2 ready before request", {31'b0, req_ready}, 32'h1);
    start_req(v.laddr, v.root);
    chk(req_ready == 1'b0, "R2 busy after accept", {31'b0, req_ready}, 32'h0);
    chk(mem_req == 1'b1, "R3 directory read issued", {31'b0, mem_req}, 32'h1);
    chk(mem_addr == e_dir, "R3 directory entry address", mem_addr, e_dir);
    respond(v.pde, v.lat);
    if (!v.pde[0]) begin
      chk(fault == 1'b1, "R6 fault on directory entry", {31'b0, fault}, 32'h1);
      chk(fault_laddr == v.laddr, "R6 fault address", fault_laddr, v.laddr);
      chk(mem_req == 1'b0, "R6 no table read", {31'b0, mem_req}, 32'h0);
      chk(done == 1'b0, "R6 no done", {31'b0, done}, 32'h0);
    end else begin
      chk(mem_req == 1'b1, "R4 table read issued", {31'b0, mem_req}, 32'h1);
      chk(mem_addr == e_tbl, "R4 table entry address", mem_addr, e_tbl);
      respond(v.pte, v.lat);
      if (!v.pte[0]) begin
        chk(fault == 1'b1, "R7 fault on table entry", {31'b0, fault}, 32'h1);
        chk(fault_laddr == v.laddr, "R7 fault address", fault_laddr, v.laddr);
        chk(done == 1'b0, "R7 no done", {31'b0, done}, 32'h0);
      end else begin
        chk(done == 1'b1, "R5 done pulse", {31'b0, done}, 32'h1);
        chk(fault == 1'b0, "R10 not both", {31'b0, fault}, 32'h0);
        chk(paddr == e_pa, "R5 physical address", paddr, e_pa);
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after end", {31'b0, req_ready}, 32'h1);
    chk((done | fault) == 1'b0, "R10 one-cycle result", {30'b0, done, fault}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    chk(mem_req == 1'b0, "R1 no request in reset", {31'b0, mem_req}, 32'h0);
    chk((done | fault) == 1'b0, "R1 no result in reset", {30'b0, done, fault}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: stray strobe while idle
    mem_rvalid = 1'b1;
    mem_rdata  = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    chk(req_ready == 1'b1, "R9 stray strobe keeps idle", {31'b0, req_ready}, 32'h1);
    chk((done | fault | mem_req) == 1'b0, "R9 stray strobe no effect",
        {29'b0, done, fault, mem_req}, 32'h0);
    run_vec(VECS[2]);

    // R2: request during a walk is ignored
    start_req(32'h0040_3123, 32'h0010_0000);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = 32'hDEAD_BEEF;
    req_root  = 32'hAAAA_A000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_addr == 32'h0010_0004, "R2 address unchanged while busy",
        mem_addr, 32'h0010_0004);
    mem_rvalid = 1'b1; mem_rdata = 32'h0020_0001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h0ABC_D007;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(paddr == 32'h0ABC_D123, "R2 result from first request", paddr, 32'h0ABC_D123);
    @(negedge clk);
    @(negedge clk);
    chk(mem_req == 1'b0, "R2 no walk from ignored request", {31'b0, mem_req}, 32'h0);

    // R1: reset in the middle of a walk
    start_req(32'h0040_3123, 32'h0010_0000);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0, "R1 reset mid-walk",
        {30'b0, req_ready, mem_req}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VECS[0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule